// File: doc/BRIEF.md
# Floating-Point to Self-Aligned Format Encoder

The encoder turns one binary floating-point word, given as sign, biased exponent and fraction, into a self-aligned form that downstream integer adders can sum without any normalization step. The low `DROP_L` bits of the exponent are taken out of the exponent and turned into a fixed left shift of the significand. What remains of the exponent is a short reduced exponent. The value is `mant * 2^(2^DROP_L * (redExp - b))` for a bias `b` chosen by the consumer.

The significand gets back its hidden leading one. It is shifted left by the dropped exponent bits and by `GUARD_W` guard positions. It is then widened at the top by `log2(TERMS)` headroom bits plus a sign bit, and is negated in two's complement when the sign is set. The dropped low exponent bits also come out as a separate shift field. An exponent of zero is treated as zero, so every output field is zero. The block has one register stage: each word presented with `inValid` gives a result one clock later.

With the default parameters (8-bit exponent, 23-bit fraction, `DROP_L`=5, 16 terms, 3 guard bits), the mantissa is 63 bits wide, the reduced exponent is 3 bits and the shift field is 5 bits.

Top module: `saf_encoder`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `outValid` is 0 and `outExp`, `outMant` and `outShift` are all zero.
- R2: `outValid` is high in exactly those cycles that follow a rising clock edge at which `inValid` was high.
- R3: After a capture, `outExp` equals `inExp >> DROP_L`, the exponent with its `DROP_L` least significant bits removed.
- R4: After a capture with nonzero exponent, `outShift` equals `inExp[DROP_L-1:0]`.
- R5: After a capture with nonzero exponent and `inSign`=0, `outMant` equals `{1'b1, inFrac}` shifted left by `inExp[DROP_L-1:0] + GUARD_W`, zero-extended to `MANT_W` bits.
- R6: After a capture with nonzero exponent and `inSign`=1, `outMant` equals the `MANT_W`-bit two's complement of the R5 magnitude.
- R7: After a capture with `inExp`=0, `outExp`, `outMant` and `outShift` are all zero, whatever `inSign` and `inFrac` are.
- R8: In a cycle where `inValid` is low, `outExp`, `outMant` and `outShift` keep their previous values, whatever the data inputs carry.
- R9: The lowest `GUARD_W` bits of `outMant` are always zero. The top `HEAD_W+1` bits of `outMant` all equal the sign of the result, even for the largest fraction with the largest shift.
- R10: An all-ones exponent gets no special handling. It is encoded by the same rules as R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word valid strobe |
| inSign | input | 1 | Sign of the input word |
| inExp | input | EXP_W | Biased exponent of the input word |
| inFrac | input | FRAC_W | Fraction, without the hidden one |
| outValid | output | 1 | Result valid, one clock after inValid |
| outExp | output | EXP_W-DROP_L | Reduced exponent |
| outMant | output | MANT_W | Extended mantissa, two's complement |
| outShift | output | DROP_L | Dropped low exponent bits (left shift amount) |

## Verification
A fault in the shifter stages or the shift amount shows up on `outMant` one clock after a capture. The leading one of the result sits at the wrong bit, so exponents are swept across every low-bit value. A bad negation or sign merge breaks the all-equal top bits and the two's complement relation at that same sample. A capture register loaded on the wrong strobe shows in the first idle cycle after a capture, as changed outputs while `inValid` is low. Zero-exponent words with nonzero fraction and a set sign expose a missing zero force at once.

// File: rtl/saf_pkg.sv
package saf_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic capture;    // load the output registers this edge
    logic zeroForce;  // input is zero/subnormal: encode as all-zero
  } ctrlStrobes_t;

endpackage

// File: rtl/saf_shifter.sv
// Logarithmic left shifter: one mux stage per bit of the shift amount.
module saf_shifter #(
  parameter int DATA_W = 63,
  parameter int AMT_W  = 6
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] stageVal [AMT_W+1];

  assign stageVal[0] = dataIn;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (STEP < DATA_W) begin : g_shift
      assign stageVal[s+1] = shiftAmt[s] ? (stageVal[s] << STEP) : stageVal[s];
    end else begin : g_flush
      assign stageVal[s+1] = shiftAmt[s] ? '0 : stageVal[s];
    end
  end

  assign dataOut = stageVal[AMT_W];

endmodule

// File: rtl/saf_ctrl.sv
// Control half: derives strobes and tracks result validity.
module saf_ctrl
  import saf_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [EXP_W-1:0] inExp,
  output ctrlStrobes_t     strobes,
  output logic             outValid
);

  always_comb begin
    strobes.capture   = inValid;
    strobes.zeroForce = (inExp == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

  // R2: result valid follows input valid by exactly one edge
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/saf_datapath.sv
// Datapath half: restore hidden one, self-align, merge sign, register.
module saf_datapath
  import saf_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int DROP_L  = 5,
  parameter int HEAD_W  = 4,
  parameter int GUARD_W = 3,
  parameter int MANT_W  = 63
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobes_t             strobes,
  input  logic                     inSign,
  input  logic [EXP_W-1:0]         inExp,
  input  logic [FRAC_W-1:0]        inFrac,
  output logic [EXP_W-DROP_L-1:0]  outExp,
  output logic [MANT_W-1:0]        outMant,
  output logic [DROP_L-1:0]        outShift
);

  localparam int RED_W   = EXP_W - DROP_L;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int MAX_AMT = (1 << DROP_L) - 1 + GUARD_W;
  localparam int AMT_W   = $clog2(MAX_AMT + 1);

  logic [DROP_L-1:0] lowBits;
  logic [RED_W-1:0]  redExp;
  logic [SIG_W-1:0]  significand;
  logic [MANT_W-1:0] sigWide;
  logic [AMT_W-1:0]  alignAmt;
  logic [MANT_W-1:0] magnitude;
  logic [MANT_W-1:0] signedMant;

  always_comb begin
    lowBits     = strobes.zeroForce ? '0 : inExp[DROP_L-1:0];
    redExp      = strobes.zeroForce ? '0 : inExp[EXP_W-1:DROP_L];
    significand = strobes.zeroForce ? '0 : {1'b1, inFrac};
    sigWide     = MANT_W'(significand);
    alignAmt    = AMT_W'(lowBits) + AMT_W'(GUARD_W);
  end

  saf_shifter #(
    .DATA_W (MANT_W),
    .AMT_W  (AMT_W)
  ) u_shifter (
    .dataIn   (sigWide),
    .shiftAmt (alignAmt),
    .dataOut  (magnitude)
  );

  always_comb begin
    if (inSign) begin
      signedMant = (~magnitude) + MANT_W'(1);
    end else begin
      signedMant = magnitude;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outExp   <= '0;
      outMant  <= '0;
      outShift <= '0;
    end else if (strobes.capture) begin
      outExp   <= redExp;
      outMant  <= signedMant;
      outShift <= lowBits;
    end
  end

  // R7: zero exponent yields all-zero fields
  assert_zero_input_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && inExp == '0) |=> (outMant == '0 && outExp == '0 && outShift == '0));

  // R4: shift field carries the dropped low exponent bits
  assert_shift_field_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && inExp != '0) |=> outShift == $past(inExp[DROP_L-1:0]));

  // R8: no capture, no change
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(outMant) && $stable(outExp) && $stable(outShift)));

  // R9: headroom bits all replicate the sign, guard bits stay clear
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (outMant[MANT_W-1 -: HEAD_W+1] == '0) || (outMant[MANT_W-1 -: HEAD_W+1] == '1));
  assert_guard_clear_R9: assert property (@(posedge clk) disable iff (rst)
    outMant[GUARD_W-1:0] == '0);

endmodule

// File: rtl/saf_encoder.sv
// Thin top: floating-point word to self-aligned (redExp, mant, shift).
module saf_encoder
  import saf_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int DROP_L  = 5,
  parameter int TERMS   = 16,
  parameter int GUARD_W = 3,
  localparam int HEAD_W = $clog2(TERMS),
  localparam int SPAN_W = (1 << DROP_L) - 1,
  localparam int MANT_W = 2 + FRAC_W + SPAN_W + GUARD_W + HEAD_W,
  localparam int RED_W  = EXP_W - DROP_L
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [FRAC_W-1:0] inFrac,
  output logic              outValid,
  output logic [RED_W-1:0]  outExp,
  output logic [MANT_W-1:0] outMant,
  output logic [DROP_L-1:0] outShift
);

  ctrlStrobes_t strobes;

  saf_ctrl #(
    .EXP_W (EXP_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inExp    (inExp),
    .strobes  (strobes),
    .outValid (outValid)
  );

  saf_datapath #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .DROP_L  (DROP_L),
    .HEAD_W  (HEAD_W),
    .GUARD_W (GUARD_W),
    .MANT_W  (MANT_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inSign   (inSign),
    .inExp    (inExp),
    .inFrac   (inFrac),
    .outExp   (outExp),
    .outMant  (outMant),
    .outShift (outShift)
  );

endmodule

// File: tb/saf_encoder_tb.sv
module saf_encoder_tb;

  localparam int EXP_W = 8;
  localparam int FRAC_W = 23;
  localparam int DROP_L = 5;
  localparam int GUARD_W = 3;
  localparam int MANT_W = 63;
  localparam int RED_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inSign = 1'b0;
  logic [EXP_W-1:0] inExp = '0;
  logic [FRAC_W-1:0] inFrac = '0;
  logic outValid;
  logic [RED_W-1:0] outExp;
  logic [MANT_W-1:0] outMant;
  logic [DROP_L-1:0] outShift;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  saf_encoder u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSign(inSign),
    .inExp(inExp), .inFrac(inFrac), .outValid(outValid),
    .outExp(outExp), .outMant(outMant), .outShift(outShift)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [MANT_W-1:0] modelMant(input logic s, input logic [EXP_W-1:0] e,
                                                  input logic [FRAC_W-1:0] f);
    logic [63:0] m;
    if (e == 0) return '0;
    m = {40'b0, 1'b1, f};
    m = m << (int'(e[DROP_L-1:0]) + GUARD_W);
    if (s) m = -m;
    return m[MANT_W-1:0];
  endfunction

  // drive at negedge, capture on next posedge, sample at the following negedge
  task automatic encodeAndCheck(input string req, input logic s, input logic [EXP_W-1:0] e,
                                input logic [FRAC_W-1:0] f);
    @(negedge clk);
    inValid = 1'b1; inSign = s; inExp = e; inFrac = f;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid R2"}, 64'(outValid), 64'd1);
    check({req, " redExp R3"}, 64'(outExp), (e == 0) ? 64'd0 : 64'(e >> DROP_L));
    check({req, " shift R4"}, 64'(outShift), (e == 0) ? 64'd0 : 64'(e[DROP_L-1:0]));
    check({req, " mant"}, 64'(outMant), 64'(modelMant(s, e, f)));
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(outValid), 0);
    check("R1 mant in reset", 64'(outMant), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 64'(outValid), 0);
    check("R1 fields after reset", {outExp, outShift}, 0);
    check("R1 mant after reset", 64'(outMant), 0);
  endtask

  task automatic testPositive();
    for (int k = 1; k < 256; k += 37) begin
      encodeAndCheck("R5 positive", 1'b0, EXP_W'(k), FRAC_W'(k * 12345));
    end
    encodeAndCheck("R5 exp=1 frac=0", 1'b0, 8'd1, '0);
  endtask

  task automatic testNegative();
    for (int k = 3; k < 256; k += 41) begin
      encodeAndCheck("R6 negative", 1'b1, EXP_W'(k), FRAC_W'(k * 777));
    end
  endtask

  task automatic testShiftSweep();
    for (int k = 0; k < 32; k++) begin
      encodeAndCheck("R4 R5 shift sweep", k[0], EXP_W'(64 + k), 23'h2AAAAA);
    end
  endtask

  task automatic testZeroExp();
    encodeAndCheck("R7 zero exp neg", 1'b1, 8'd0, 23'h7FFFFF);
    check("R7 all zero", {outExp, outShift, outMant}, 0);
    encodeAndCheck("R7 zero exp pos", 1'b0, 8'd0, 23'h000001);
  endtask

  task automatic testHeadroom();
    encodeAndCheck("R9 max pos", 1'b0, 8'hDF, 23'h7FFFFF);
    check("R9 pos top bits", 64'(outMant[MANT_W-1 -: 5]), 0);
    check("R9 pos guard", 64'(outMant[GUARD_W-1:0]), 0);
    encodeAndCheck("R9 max neg", 1'b1, 8'hDF, 23'h7FFFFF);
    check("R9 neg top bits", 64'(outMant[MANT_W-1 -: 5]), 64'h1F);
  endtask

  task automatic testAllOnesExp();
    encodeAndCheck("R10 all-ones exp", 1'b0, 8'hFF, 23'h400000);
    encodeAndCheck("R10 all-ones exp neg", 1'b1, 8'hFF, '0);
  endtask

  task automatic testHold();
    logic [MANT_W-1:0] keepMant;
    logic [RED_W-1:0] keepExp;
    logic [DROP_L-1:0] keepShift;
    encodeAndCheck("R8 setup", 1'b1, 8'h95, 23'h123456);
    keepMant = outMant; keepExp = outExp; keepShift = outShift;
    inSign = 1'b0; inExp = 8'h3C; inFrac = 23'h7F00FF;
    repeat (3) @(negedge clk);
    check("R8 mant held", 64'(outMant), 64'(keepMant));
    check("R8 fields held", {keepExp, keepShift}, {outExp, outShift});
    check("R2 idle valid", 64'(outValid), 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    inValid = 1'b1; inSign = 1'b0; inExp = 8'h41; inFrac = 23'h000010;
    @(negedge clk);
    check("R2 b2b first valid", 64'(outValid), 1);
    check("R5 b2b first mant", 64'(outMant), 64'(modelMant(1'b0, 8'h41, 23'h000010)));
    inSign = 1'b1; inExp = 8'h7E; inFrac = 23'h0F0F0F;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 b2b second valid", 64'(outValid), 1);
    check("R6 b2b second mant", 64'(outMant), 64'(modelMant(1'b1, 8'h7E, 23'h0F0F0F)));
    @(negedge clk);
    check("R2 b2b drop", 64'(outValid), 0);
  endtask

  initial begin
    testReset();
    testPositive();
    testNegative();
    testShiftSweep();
    testZeroExp();
    testHeadroom();
    testAllOnesExp();
    testHold();
    testBackToBack();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule